// File: doc/BRIEF.md
# Multi-Mode Pointer-Addressed Frame Buffer

This block manages a small on-chip memory made of two equal banks, one per channel, and runs it in one of several ways chosen by a 3-bit mode input. In FIFO mode it queues words between a producer and a consumer. In shift mode it acts as a delay line whose depth is programmable. In frame-store mode any location can be written or read through external addresses. Every channel keeps its own write and read pointer. Either pointer can be cleared to zero or loaded with any address while the block runs. Reading never removes data, so a rewound read pointer gives the same words again until they are overwritten. All ports use a single clock.

Data moves over valid/ready streams, one input stream and one output stream per channel. A word is taken in a cycle where `x_in_valid` and `x_in_ready` are both high. A word is delivered in a cycle where `x_out_valid` and `x_out_ready` are both high. In FIFO mode, ready and valid depend only on occupancy. In shift mode the input can advance only when the output is able to, so `x_in_ready` follows `x_out_ready` and `x_out_valid` follows `x_in_valid`. In frame-store mode both directions are always open. In the joined modes the two banks form one channel of twice the width, controlled through channel A's handshake and pointer pins. Channel B's stream pins are then idle.

A bank of sixteen 8-bit configuration registers holds the shift latencies and the flag thresholds. Each channel reports partially-empty, partially-full and collision flags.

Top module: `mmfb_core`

## Requirements
- R1: The mode input selects the operation: 0 is a joined FIFO, 1 is a two-channel FIFO, 2 is a joined shift line, 3 is a two-channel shift line and 4 is a joined frame store. Codes 5 to 7 hold every `in_ready` and `out_valid` low and write nothing to memory.
- R2: In FIFO mode, occupancy is (write pointer − read pointer) mod DEPTH. `out_valid` is high when occupancy is nonzero, with `out_data` giving the word at the read pointer. `in_ready` is low when occupancy is DEPTH−1. Each accepted word advances the write pointer by one, and each delivered word advances the read pointer by one.
- R3: A read does not change memory. Rewinding the read pointer to an earlier address presents the same word again.
- R4: When a clear strobe (`x_wclr` or `x_rclr`) is high at a clock edge, the matching pointer becomes 0. A clear takes priority over a set strobe and over advancing in the same cycle.
- R5: When a set strobe (`x_wset` or `x_rset`) is high at a clock edge and the matching clear is not, the pointer is loaded from `ld_addr`.
- R6: In frame-store mode, an accepted word is written at `fs_waddr` and `out_data` shows the contents at `fs_raddr` in the same cycle. `in_ready` and `out_valid` are held high.
- R7: In shift mode, the word presented alongside an accepted input is the one accepted L transfers earlier. L is the latency register of that channel taken mod DEPTH (register 0 for channel A, register 1 for channel B). `in_ready` equals `out_ready`.
- R8: In the two-channel modes, each channel has its own pointers, handshake and latency, and they do not interact.
- R9: In the joined modes, a word is {`b_in_data`, `a_in_data`} and is delivered as `b_out_data` (upper half) and `a_out_data` (lower half). `b_in_ready` and `b_out_valid` stay low.
- R10: `x_pe` is high when occupancy ≤ the channel's partially-empty threshold. `x_pf` is high when occupancy ≥ its partially-full threshold. Channel A's thresholds are in registers 2 and 3, and channel B's are in registers 4 and 5.
- R11: `x_collide` is high for the one cycle after an edge at which that channel both accepted and delivered a word at the same address. The delivered word is the old contents.
- R12: A configuration write (`cfg_we`) stores `cfg_wdata` at `cfg_addr`. `cfg_rdata` shows the register at `cfg_addr` without delay. All sixteen registers reset to 0.
- R13: After reset, all pointers are 0 and both collision flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every port |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Operating mode code |
| a_in_valid | input | 1 | Channel A input word valid |
| a_in_ready | output | 1 | Channel A can accept |
| a_in_data | input | DATA_W | Channel A input word |
| a_out_valid | output | 1 | Channel A output word valid |
| a_out_ready | input | 1 | Channel A consumer ready |
| a_out_data | output | DATA_W | Channel A output word |
| b_in_valid | input | 1 | Channel B input word valid |
| b_in_ready | output | 1 | Channel B can accept |
| b_in_data | input | DATA_W | Channel B input word / upper half |
| b_out_valid | output | 1 | Channel B output word valid |
| b_out_ready | input | 1 | Channel B consumer ready |
| b_out_data | output | DATA_W | Channel B output word / upper half |
| a_wclr | input | 1 | Clear A write pointer |
| a_rclr | input | 1 | Clear A read pointer |
| a_wset | input | 1 | Load A write pointer |
| a_rset | input | 1 | Load A read pointer |
| b_wclr | input | 1 | Clear B write pointer |
| b_rclr | input | 1 | Clear B read pointer |
| b_wset | input | 1 | Load B write pointer |
| b_rset | input | 1 | Load B read pointer |
| ld_addr | input | ADDR_W | Value loaded by set strobes |
| fs_waddr | input | ADDR_W | Frame-store write address |
| fs_raddr | input | ADDR_W | Frame-store read address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| a_pe | output | 1 | Channel A partially empty |
| a_pf | output | 1 | Channel A partially full |
| a_collide | output | 1 | Channel A same-address collision |
| b_pe | output | 1 | Channel B partially empty |
| b_pf | output | 1 | Channel B partially full |
| b_collide | output | 1 | Channel B same-address collision |

## Verification
The bench instantiates the block with DATA_W = 8 and ADDR_W = 3, which gives eight locations per bank. With that depth, a few words are enough to fill the FIFO to its DEPTH−1 limit, and the write pointer wraps over the start of the array inside the vector table. Shift latencies of 2, 3 and 5 fit inside the depth, so both the delayed outputs and the separate per-channel latencies can be checked within a few transfers. The small address space also lets set, clear and frame-store addresses reach every location, including re-reads of words after the pointer has wrapped.

// File: rtl/mmfb_pkg.sv
package mmfb_pkg;

  typedef enum logic [1:0] {
    KIND_OFF   = 2'd0,
    KIND_FIFO  = 2'd1,
    KIND_SHIFT = 2'd2,
    KIND_FRAME = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  dual;
  } mode_t;

  localparam int CFG_REGS = 16;
  localparam int CFG_W    = 8;
  localparam int CFG_AW   = $clog2(CFG_REGS);

  localparam int CFG_LAT_A = 0;
  localparam int CFG_LAT_B = 1;
  localparam int CFG_PE_A  = 2;
  localparam int CFG_PF_A  = 3;
  localparam int CFG_PE_B  = 4;
  localparam int CFG_PF_B  = 5;

  function automatic mode_t decode_mode(input logic [2:0] code);
    mode_t m;
    case (code)
      3'd0:    m = '{kind: KIND_FIFO,  dual: 1'b0};
      3'd1:    m = '{kind: KIND_FIFO,  dual: 1'b1};
      3'd2:    m = '{kind: KIND_SHIFT, dual: 1'b0};
      3'd3:    m = '{kind: KIND_SHIFT, dual: 1'b1};
      3'd4:    m = '{kind: KIND_FRAME, dual: 1'b0};
      default: m = '{kind: KIND_OFF,   dual: 1'b0};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mmfb_cfg_bank.sv
module mmfb_cfg_bank
  import mmfb_pkg::*;
#(
  parameter int REGS = CFG_REGS,
  parameter int W    = CFG_W,
  localparam int AW  = $clog2(REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [W-1:0]          wdata,
  output logic [W-1:0]          rdata,
  output logic [REGS-1:0][W-1:0] regs
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (we) begin
      regs[addr] <= wdata;
    end
  end

  assign rdata = regs[addr];

  AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(addr)] == $past(wdata)); // R12

endmodule

// File: rtl/mmfb_mem_bank.sv
module mmfb_mem_bank #(
  parameter int W  = 8,
  parameter int AW = 5,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // Read is combinational: a same-cycle write lands at the edge, so the
  // read in that cycle sees the previous contents.
  assign rdata = cells[raddr];

endmodule

// File: rtl/mmfb_chan_ctrl.sv
module mmfb_chan_ctrl
  import mmfb_pkg::*;
#(
  parameter int AW = 5,
  parameter int CW = CFG_W,
  localparam int XW = (CW > AW) ? CW : AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  kind_e         kind,
  input  logic          en,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  input  logic          wclr,
  input  logic          rclr,
  input  logic          wset,
  input  logic          rset,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] ext_waddr,
  input  logic [AW-1:0] ext_raddr,
  input  logic [CW-1:0] lat,
  input  logic [CW-1:0] pe_thr,
  input  logic [CW-1:0] pf_thr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          pe,
  output logic          pf,
  output logic          collide
);

  logic [AW-1:0] wp, rp, occ;
  logic [XW-1:0] occ_x, tap_x;
  logic          is_fifo, is_shift, is_frame;
  logic          wr_fire, rd_fire;
  logic          tap_unused;

  assign is_fifo  = en && (kind == KIND_FIFO);
  assign is_shift = en && (kind == KIND_SHIFT);
  assign is_frame = en && (kind == KIND_FRAME);

  assign occ   = wp - rp;
  assign occ_x = XW'(occ);
  assign tap_x = XW'(wp) - XW'(lat);
  assign tap_unused = ^tap_x[XW-1:AW];

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    waddr     = wp;
    raddr     = rp;
    if (is_fifo) begin
      in_ready  = (occ != '1);
      out_valid = (occ != '0);
    end else if (is_shift) begin
      in_ready  = out_ready;
      out_valid = in_valid;
      raddr     = tap_x[AW-1:0];
    end else if (is_frame) begin
      in_ready  = 1'b1;
      out_valid = 1'b1;
      waddr     = ext_waddr;
      raddr     = ext_raddr;
    end
  end

  assign wr_fire = in_valid && in_ready;
  assign rd_fire = out_valid && out_ready;
  assign we      = wr_fire;

  assign pe = (occ_x <= XW'(pe_thr));
  assign pf = (occ_x >= XW'(pf_thr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
    end else if (wclr) begin
      wp <= '0;
    end else if (wset) begin
      wp <= ld_addr;
    end else if (wr_fire && !is_frame) begin
      wp <= wp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp <= '0;
    end else if (rclr) begin
      rp <= '0;
    end else if (rset) begin
      rp <= ld_addr;
    end else if (is_fifo && rd_fire) begin
      rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) collide <= 1'b0;
    else        collide <= wr_fire && rd_fire && (waddr == raddr);
  end

  AST_WCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wclr |=> wp == '0); // R4

  AST_RSET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rset && !rclr) |=> rp == $past(ld_addr)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fifo && in_valid && !in_ready && !wclr && !wset) |=> $stable(wp)); // R2

  AST_FIFO_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fifo && rd_fire && !rclr && !rset) |=> rp == $past(rp) + 1'b1); // R2

endmodule

// File: rtl/mmfb_core.sv
module mmfb_core
  import mmfb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  localparam int NCH   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              a_in_valid,
  output logic              a_in_ready,
  input  logic [DATA_W-1:0] a_in_data,
  output logic              a_out_valid,
  input  logic              a_out_ready,
  output logic [DATA_W-1:0] a_out_data,
  input  logic              b_in_valid,
  output logic              b_in_ready,
  input  logic [DATA_W-1:0] b_in_data,
  output logic              b_out_valid,
  input  logic              b_out_ready,
  output logic [DATA_W-1:0] b_out_data,
  input  logic              a_wclr,
  input  logic              a_rclr,
  input  logic              a_wset,
  input  logic              a_rset,
  input  logic              b_wclr,
  input  logic              b_rclr,
  input  logic              b_wset,
  input  logic              b_rset,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [ADDR_W-1:0] fs_waddr,
  input  logic [ADDR_W-1:0] fs_raddr,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              a_pe,
  output logic              a_pf,
  output logic              a_collide,
  output logic              b_pe,
  output logic              b_pf,
  output logic              b_collide
);

  mode_t mcfg;
  assign mcfg = decode_mode(mode);

  logic [CFG_REGS-1:0][CFG_W-1:0] cfg_regs;
  logic                           cfg_unused;

  mmfb_cfg_bank #(.REGS(CFG_REGS), .W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .regs  (cfg_regs)
  );
  assign cfg_unused = ^cfg_regs;

  // Per-channel views of the edge pins.
  logic [NCH-1:0]             in_valid, in_ready, out_valid, out_ready;
  logic [NCH-1:0]             wclr, rclr, wset, rset, en;
  logic [NCH-1:0]             pe, pf, collide, ch_we;
  logic [NCH-1:0][DATA_W-1:0] in_data, out_data;
  logic [NCH-1:0][ADDR_W-1:0] ch_waddr, ch_raddr;
  logic [NCH-1:0][CFG_W-1:0]  lat, pe_thr, pf_thr;

  assign in_valid  = {b_in_valid, a_in_valid};
  assign out_ready = {b_out_ready, a_out_ready};
  assign wclr      = {b_wclr, a_wclr};
  assign rclr      = {b_rclr, a_rclr};
  assign wset      = {b_wset, a_wset};
  assign rset      = {b_rset, a_rset};
  assign in_data   = {b_in_data, a_in_data};
  assign lat       = {cfg_regs[CFG_LAT_B], cfg_regs[CFG_LAT_A]};
  assign pe_thr    = {cfg_regs[CFG_PE_B],  cfg_regs[CFG_PE_A]};
  assign pf_thr    = {cfg_regs[CFG_PF_B],  cfg_regs[CFG_PF_A]};

  assign en[0] = (mcfg.kind != KIND_OFF);
  assign en[1] = (mcfg.kind != KIND_OFF) && mcfg.dual;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic              bank_we;
      logic [ADDR_W-1:0] bank_wa, bank_ra;

      mmfb_chan_ctrl #(.AW(ADDR_W), .CW(CFG_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (mcfg.kind),
        .en        (en[c]),
        .in_valid  (in_valid[c]),
        .in_ready  (in_ready[c]),
        .out_valid (out_valid[c]),
        .out_ready (out_ready[c]),
        .wclr      (wclr[c]),
        .rclr      (rclr[c]),
        .wset      (wset[c]),
        .rset      (rset[c]),
        .ld_addr   (ld_addr),
        .ext_waddr (fs_waddr),
        .ext_raddr (fs_raddr),
        .lat       (lat[c]),
        .pe_thr    (pe_thr[c]),
        .pf_thr    (pf_thr[c]),
        .we        (ch_we[c]),
        .waddr     (ch_waddr[c]),
        .raddr     (ch_raddr[c]),
        .pe        (pe[c]),
        .pf        (pf[c]),
        .collide   (collide[c])
      );

      // Joined modes drive every bank from channel 0's control.
      if (c == 0) begin : g_lead
        assign bank_we = ch_we[0];
        assign bank_wa = ch_waddr[0];
        assign bank_ra = ch_raddr[0];
      end else begin : g_follow
        assign bank_we = mcfg.dual ? ch_we[c]    : ch_we[0];
        assign bank_wa = mcfg.dual ? ch_waddr[c] : ch_waddr[0];
        assign bank_ra = mcfg.dual ? ch_raddr[c] : ch_raddr[0];
      end

      mmfb_mem_bank #(.W(DATA_W), .AW(ADDR_W)) u_bank (
        .clk   (clk),
        .we    (bank_we),
        .waddr (bank_wa),
        .wdata (in_data[c]),
        .raddr (bank_ra),
        .rdata (out_data[c])
      );
    end
  endgenerate

  assign a_in_ready  = in_ready[0];
  assign b_in_ready  = in_ready[1];
  assign a_out_valid = out_valid[0];
  assign b_out_valid = out_valid[1];
  assign a_out_data  = out_data[0];
  assign b_out_data  = out_data[1];
  assign a_pe        = pe[0];
  assign a_pf        = pf[0];
  assign a_collide   = collide[0];
  assign b_pe        = pe[1];
  assign b_pf        = pf[1];
  assign b_collide   = collide[1];

  AST_JOIN_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mcfg.dual |-> (!b_in_ready && !b_out_valid)); // R9

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > 3'd4) |-> (!a_in_ready && !a_out_valid && !b_in_ready)); // R1

endmodule

// File: tb/sim_mmfb_core.sv
`timescale 1ns/1ps
module sim_mmfb_core;

  localparam int DW = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [2:0]    mode;
  logic          a_in_valid, a_in_ready, a_out_valid, a_out_ready;
  logic          b_in_valid, b_in_ready, b_out_valid, b_out_ready;
  logic [DW-1:0] a_in_data, a_out_data, b_in_data, b_out_data;
  logic          a_wclr, a_rclr, a_wset, a_rset, b_wclr, b_rclr, b_wset, b_rset;
  logic [AW-1:0] ld_addr, fs_waddr, fs_raddr;
  logic          cfg_we;
  logic [3:0]    cfg_addr;
  logic [7:0]    cfg_wdata, cfg_rdata;
  logic          a_pe, a_pf, a_collide, b_pe, b_pf, b_collide;

  mmfb_core #(.DATA_W(DW), .ADDR_W(AW)) u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    a_in_valid = 0; b_in_valid = 0; a_out_ready = 0; b_out_ready = 0;
    a_wclr = 0; a_rclr = 0; a_wset = 0; a_rset = 0;
    b_wclr = 0; b_rclr = 0; b_wset = 0; b_rset = 0;
    cfg_we = 0;
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1;
    step();
    cfg_we = 0;
  endtask

  typedef struct packed {
    logic       iv;
    logic [7:0] d;
    logic       ordy;
    logic       ir;
    logic       ov;
    logic [7:0] q;
    logic       pe;
    logic       pf;
  } vec_t;

  // Channel A, mode 1, DEPTH 8, pe threshold 2, pf threshold 6.
  localparam vec_t VEC [14] = '{
    '{1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},
    '{1'b1, 8'h22, 1'b1, 1'b1, 1'b1, 8'h11, 1'b1, 1'b0},
    '{1'b1, 8'h33, 1'b0, 1'b1, 1'b1, 8'h22, 1'b1, 1'b0},
    '{1'b1, 8'h44, 1'b0, 1'b1, 1'b1, 8'h22, 1'b1, 1'b0},
    '{1'b1, 8'h55, 1'b0, 1'b1, 1'b1, 8'h22, 1'b0, 1'b0},
    '{1'b1, 8'h66, 1'b0, 1'b1, 1'b1, 8'h22, 1'b0, 1'b0},
    '{1'b1, 8'h77, 1'b0, 1'b1, 1'b1, 8'h22, 1'b0, 1'b0},
    '{1'b1, 8'h88, 1'b0, 1'b1, 1'b1, 8'h22, 1'b0, 1'b1},
    '{1'b1, 8'h99, 1'b0, 1'b0, 1'b1, 8'h22, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h22, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h33, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h44, 1'b0, 1'b0},
    '{1'b1, 8'hAA, 1'b1, 1'b1, 1'b1, 8'h55, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h66, 1'b0, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    quiet();
    rst_n = 0; mode = 3'd1; a_in_data = 0; b_in_data = 0;
    ld_addr = 0; fs_waddr = 0; fs_raddr = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R13 collide after reset", {15'd0, a_collide}, 16'd0);
    chk("R13 empty pe after reset", {15'd0, a_pe}, 16'd1);
    chk("R13 out_valid after reset", {15'd0, a_out_valid}, 16'd0);
    chk("R12 cfg reset value", {8'd0, cfg_rdata}, 16'd0);
    @(negedge clk);

    cfg_write(4'd2, 8'd2);
    cfg_write(4'd3, 8'd6);

    // R2 R10 vector table
    for (int i = 0; i < 14; i++) begin
      a_in_valid = VEC[i].iv; a_in_data = VEC[i].d; a_out_ready = VEC[i].ordy;
      #1;
      chk($sformatf("R2 in_ready v%0d", i), {15'd0, a_in_ready}, {15'd0, VEC[i].ir});
      chk($sformatf("R2 out_valid v%0d", i), {15'd0, a_out_valid}, {15'd0, VEC[i].ov});
      if (VEC[i].ov) chk($sformatf("R2 out_data v%0d", i), {8'd0, a_out_data}, {8'd0, VEC[i].q});
      chk($sformatf("R10 pe v%0d", i), {15'd0, a_pe}, {15'd0, VEC[i].pe});
      chk($sformatf("R10 pf v%0d", i), {15'd0, a_pf}, {15'd0, VEC[i].pf});
      step();
    end
    quiet();

    // R3 rewind and re-read
    a_rset = 1; ld_addr = 3'd2; step(); a_rset = 0;
    #1 chk("R3 first re-read", {8'd0, a_out_data}, 16'h33);
    a_out_ready = 1; step(); a_out_ready = 0;
    a_rset = 1; ld_addr = 3'd2; step(); a_rset = 0;
    #1 chk("R3 second re-read", {8'd0, a_out_data}, 16'h33);

    // R4 clear beats set
    a_rclr = 1; a_wclr = 1; a_wset = 1; ld_addr = 3'd5; step(); quiet();
    #1 chk("R4 clear wins, empty", {15'd0, a_out_valid}, 16'd0);

    // R5 set write pointer
    a_wset = 1; ld_addr = 3'd3; step(); quiet();
    #1;
    chk("R5 occupancy 3 valid", {15'd0, a_out_valid}, 16'd1);
    chk("R5 data at zero", {8'd0, a_out_data}, 16'hAA);
    chk("R10 pe at occ 3", {15'd0, a_pe}, 16'd0);

    // R1 reserved mode writes nothing
    mode = 3'd5; a_in_valid = 1; a_in_data = 8'hEE; a_out_ready = 1;
    #1;
    chk("R1 reserved in_ready", {15'd0, a_in_ready}, 16'd0);
    chk("R1 reserved out_valid", {15'd0, a_out_valid}, 16'd0);
    step(); quiet(); mode = 3'd1;
    a_rset = 1; a_wset = 1; ld_addr = 3'd3; step(); quiet();
    a_wset = 1; ld_addr = 3'd4; step(); quiet();
    #1 chk("R1 memory untouched", {8'd0, a_out_data}, 16'h44);

    // R12 register readback
    cfg_write(4'd9, 8'hC3);
    cfg_addr = 4'd9; #1 chk("R12 readback", {8'd0, cfg_rdata}, 16'h00C3);
    cfg_addr = 4'd10; #1 chk("R12 neighbour intact", {8'd0, cfg_rdata}, 16'd0);
    @(negedge clk);

    // R6 R9 frame store
    mode = 3'd4; a_in_valid = 1; a_in_data = 8'h5A; b_in_data = 8'h5B;
    b_in_valid = 1; b_out_ready = 1;
    fs_waddr = 3'd5; fs_raddr = 3'd0;
    #1;
    chk("R9 b_in_ready low joined", {15'd0, b_in_ready}, 16'd0);
    chk("R9 b_out_valid low joined", {15'd0, b_out_valid}, 16'd0);
    chk("R6 in_ready high", {15'd0, a_in_ready}, 16'd1);
    step(); quiet();
    fs_raddr = 3'd5;
    #1;
    chk("R6 random read low half", {8'd0, a_out_data}, 16'h5A);
    chk("R9 upper half on b", {8'd0, b_out_data}, 16'h5B);

    // R11 collision returns old data
    a_in_valid = 1; a_in_data = 8'h66; b_in_data = 8'h77; a_out_ready = 1;
    #1 chk("R11 old data on collision", {8'd0, a_out_data}, 16'h5A);
    step(); quiet();
    #1;
    chk("R11 collide raised", {15'd0, a_collide}, 16'd1);
    chk("R6 new data stored", {8'd0, a_out_data}, 16'h66);
    step();
    #1 chk("R11 collide one cycle", {15'd0, a_collide}, 16'd0);

    // R7 joined shift line, latency 3
    cfg_write(4'd0, 8'd3);
    mode = 3'd2; a_wclr = 1; a_rclr = 1; step(); quiet();
    for (int k = 0; k < 7; k++) begin
      a_in_valid = 1; a_in_data = 8'(k + 1); b_in_data = 8'(k + 8'h40); a_out_ready = 1;
      #1;
      if (k >= 3) begin
        chk($sformatf("R7 delayed low k%0d", k), {8'd0, a_out_data}, 16'(k - 2));
        chk($sformatf("R9 delayed high k%0d", k), {8'd0, b_out_data}, 16'(k - 3 + 8'h40));
      end
      step();
    end
    a_out_ready = 0;
    #1 chk("R7 in_ready follows out_ready", {15'd0, a_in_ready}, 16'd0);
    quiet();
    @(negedge clk);

    // R8 two channels, latencies 2 and 5
    cfg_write(4'd0, 8'd2);
    cfg_write(4'd1, 8'd5);
    mode = 3'd3; a_wclr = 1; b_wclr = 1; step(); quiet();
    for (int k = 0; k < 8; k++) begin
      a_in_valid = 1; b_in_valid = 1; a_out_ready = 1; b_out_ready = 1;
      a_in_data = 8'(k + 1); b_in_data = 8'(k + 8'h80);
      #1;
      if (k >= 5) begin
        chk($sformatf("R8 channel A lat2 k%0d", k), {8'd0, a_out_data}, 16'(k - 1));
        chk($sformatf("R8 channel B lat5 k%0d", k), {8'd0, b_out_data}, 16'(k - 5 + 8'h80));
      end
      step();
    end
    quiet();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule